// File: doc/BRIEF.md
# Chunked Patch Staging Mailbox Responder

This block is the device side of a mailbox through which a host pushes a patch image in pieces. The host reaches it through four 32-bit registers behind a simple bus port: control, status, a write-data port and a read-data port. Each piece travels as one request object, written dword by dword into the write-data port. The object starts with a 64-bit object header, then a 64-bit command header, then the chunk payload. A go bit in control makes the block judge the request. A bad request is refused with an error status. A good one has its payload kept in a local chunk memory, and the block raises ready and prepares a four-dword reply.

The host drains the reply one dword at a time. It reads the read-data register and then writes it to acknowledge, and the acknowledge moves the block to the next dword. The reply names the byte offset in the image that the host must send next, or carries an all-ones offset once the image is complete. The block keeps its own running image offset against an image length given on an input port. A device-side input can make the block ask for the same chunk again, and a downstream consumer reads the stored chunk through a separate memory port. An abort bit in control returns everything to idle at any time.

Top module: `mbox_stager`

## Requirements
- R1: After reset, and one cycle after any write to control with bit 0 set, the status register reads 0, read-data reads 0 and the running image offset is back at 0.
- R2: The status register (byte address 0x4) shows ready in bit 31 and error in bit 2, with all other bits 0. Error is never set without ready. Reads of control (0x0) and write-data (0x8) return 0. A register read shows up on `bus_rdata` one cycle after the read strobe.
- R3: A request is accepted when all of the following hold. The first dword has `VENDOR_ID` in bits 15:0, 0x0B in bits 23:16 and 0 in bits 31:24. The second dword equals the total number of dwords written. The third dword is 3 and the fourth is 0. Between 1 and `CHUNK_DW` payload dwords follow. A go (control bit 31 with bit 0 clear) then makes status read 0x8000_0000.
- R4: After an accepted go, read-data (0xC) returns four dwords in this order: {8'h00, 8'h0B, `VENDOR_ID`}, 4, the next offset, the reply status. Any write to 0xC moves to the next dword. After the fourth acknowledge, read-data returns 0, and further acknowledges have no effect.
- R5: For an accepted chunk, the next offset is the running offset plus 4 times the payload dword count, and the reply status is 0x2 (in progress). If that sum reaches or passes `img_bytes`, the offset is 0xFFFF_FFFF and the reply status is 0x1 (success).
- R6: If `redo_chunk` is high in the cycle of an accepted go, the reply offset is the running offset unchanged, the status is 0x2, and the running offset does not move.
- R7: A go on a request that breaks any R3 rule sets status to 0x8000_0004, creates no reply (read-data returns 0) and leaves the running offset where it was.
- R8: The first write to write-data after a go clears status to 0 and starts a new request at its first dword.
- R9: Payload dword k of the last accepted request appears on `chunk_rdata` one cycle after `chunk_raddr` is k. `chunk_dwords` holds that request's payload count.
- R10: A control write with both bit 0 and bit 31 set acts as an abort only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register (bits 3:2 decoded) |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| img_bytes | input | 32 | Image length in bytes |
| redo_chunk | input | 1 | Ask again for the chunk just received |
| chunk_raddr | input | CHUNK_AW | Consumer read address into the chunk memory |
| chunk_rdata | output | 32 | Consumer read data, one cycle latency |
| chunk_dwords | output | CNT_W | Payload dwords in the last accepted chunk |

## Verification
The bench walks an image through to its final chunk, where the running offset meets the image length exactly. An off-by-one in the done test would return 64 instead of the all-ones marker. It repeats a chunk on request, aborts in the middle of a reply, and checks that acknowledges with no reply pending are ignored. A block that mishandled these would advance the offset when asked to repeat, or keep serving stale reply dwords. Each header rule is broken on its own, including one payload dword past the memory depth. A checker that let any of them through would show ready without error and a live reply. It would also move the offset that a following valid chunk reports.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [1:0]  RG_CTRL  = 2'd0;
  localparam logic [1:0]  RG_STAT  = 2'd1;
  localparam logic [1:0]  RG_WDATA = 2'd2;
  localparam logic [1:0]  RG_RDATA = 2'd3;
  localparam int          CTL_ABORT_BIT = 0;
  localparam int          CTL_GO_BIT    = 31;
  localparam logic [7:0]  OBJ_STAGE  = 8'h0B;
  localparam logic [31:0] CMD_LOAD   = 32'h3;
  localparam logic [31:0] RESP_DW    = 32'd4;
  localparam logic [31:0] OFF_END    = 32'hFFFF_FFFF;
  localparam logic [31:0] RSP_DONE   = 32'h1;
  localparam logic [31:0] RSP_MORE   = 32'h2;
  localparam int          HDR_DW     = 4;
endpackage

// File: rtl/mbox_chunk_mem.sv
module mbox_chunk_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbox_req_check.sv
module mbox_req_check
  import mbox_pkg::*;
#(
  parameter int          CHUNK_DW  = 64,
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter int          AW        = $clog2(CHUNK_DW),
  parameter int          CW        = $clog2(CHUNK_DW + HDR_DW + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_dw,
  input  logic [31:0]   wdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [CW-1:0] cnt,
  output logic          req_ok
);
  localparam int CMAX = CHUNK_DW + HDR_DW + 1;
  localparam int LAST = CHUNK_DW + HDR_DW;

  logic [31:0] hdr_lo, hdr_hi, cmd_lo, cmd_hi;
  logic        hdr_good, cmd_good, len_good;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      hdr_lo <= '0;
      hdr_hi <= '0;
      cmd_lo <= '0;
      cmd_hi <= '0;
    end else if (wr_dw) begin
      case (cnt)
        CW'(0):  hdr_lo <= wdata;
        CW'(1):  hdr_hi <= wdata;
        CW'(2):  cmd_lo <= wdata;
        CW'(3):  cmd_hi <= wdata;
        default: ;
      endcase
      if (cnt != CW'(CMAX)) cnt <= cnt + CW'(1);
    end
  end

  assign mem_we    = wr_dw && !clr && cnt >= CW'(HDR_DW) && cnt < CW'(LAST);
  assign mem_waddr = AW'(cnt - CW'(HDR_DW));

  assign hdr_good = hdr_lo[15:0] == VENDOR_ID && hdr_lo[23:16] == OBJ_STAGE &&
                    hdr_lo[31:24] == 8'h00;
  assign cmd_good = cmd_lo == CMD_LOAD && cmd_hi == 32'h0;
  assign len_good = cnt > CW'(HDR_DW) && cnt <= CW'(LAST) && hdr_hi == 32'(cnt);
  assign req_ok   = hdr_good && cmd_good && len_good;

  assert_cnt_cap_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CMAX));
  assert_clr_restart_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
endmodule

// File: rtl/mbox_resp_gen.sv
module mbox_resp_gen
  import mbox_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1A2B
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        load,
  input  logic [31:0] ld_off,
  input  logic [31:0] ld_stat,
  input  logic        ack,
  output logic        valid,
  output logic [31:0] dword
);
  logic [1:0]  idx;
  logic [31:0] off_q, stat_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid  <= 1'b0;
      idx    <= '0;
      off_q  <= '0;
      stat_q <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      idx    <= '0;
      off_q  <= ld_off;
      stat_q <= ld_stat;
    end else if (ack && valid) begin
      idx <= idx + 2'd1;
      if (idx == 2'd3) valid <= 1'b0;
    end
  end

  always_comb begin
    case (idx)
      2'd0:    dword = {8'h00, OBJ_STAGE, VENDOR_ID};
      2'd1:    dword = RESP_DW;
      2'd2:    dword = off_q;
      default: dword = stat_q;
    endcase
  end

  assert_ack_step_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && ack && !clr && !load && idx != 2'd3) |=>
      (valid && idx == $past(idx) + 2'd1));
  assert_ack_last_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && ack && !clr && !load && idx == 2'd3) |=> !valid);
endmodule

// File: rtl/mbox_stager.sv
module mbox_stager
  import mbox_pkg::*;
#(
  parameter int          CHUNK_DW  = 64,
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter int          CHUNK_AW  = $clog2(CHUNK_DW),
  parameter int          CNT_W     = $clog2(CHUNK_DW + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_rd,
  output logic [31:0]         bus_rdata,
  input  logic [31:0]         img_bytes,
  input  logic                redo_chunk,
  input  logic [CHUNK_AW-1:0] chunk_raddr,
  output logic [31:0]         chunk_rdata,
  output logic [CNT_W-1:0]    chunk_dwords
);
  localparam int CW = $clog2(CHUNK_DW + HDR_DW + 2);

  logic [1:0]          reg_sel;
  logic                abort_fire, go_fire, wd_fire, ack_fire;
  logic                st_ready, st_err;
  logic [31:0]         cur_off, sum_off, rsp_off, rsp_stat;
  logic                req_ok, resp_valid, reach_end;
  logic [31:0]         resp_dword;
  logic                mem_we;
  logic [CHUNK_AW-1:0] mem_waddr;
  logic [CW-1:0]       cnt;
  logic [CW-1:0]       pay_dw;
  logic                unused_bits;

  assign reg_sel     = bus_addr[3:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[30:1]};
  assign abort_fire  = bus_wr && reg_sel == RG_CTRL && bus_wdata[CTL_ABORT_BIT];
  assign go_fire     = bus_wr && reg_sel == RG_CTRL && bus_wdata[CTL_GO_BIT] && !abort_fire;
  assign wd_fire     = bus_wr && reg_sel == RG_WDATA;
  assign ack_fire    = bus_wr && reg_sel == RG_RDATA;

  mbox_req_check #(
    .CHUNK_DW (CHUNK_DW),
    .VENDOR_ID(VENDOR_ID),
    .AW       (CHUNK_AW),
    .CW       (CW)
  ) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (abort_fire || go_fire),
    .wr_dw    (wd_fire),
    .wdata    (bus_wdata),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .cnt      (cnt),
    .req_ok   (req_ok)
  );

  mbox_chunk_mem #(.DEPTH(CHUNK_DW), .AW(CHUNK_AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(bus_wdata),
    .raddr(chunk_raddr),
    .rdata(chunk_rdata)
  );

  assign pay_dw    = cnt - CW'(HDR_DW);
  assign sum_off   = cur_off + (32'(pay_dw) << 2);
  assign reach_end = !redo_chunk && sum_off >= img_bytes;
  assign rsp_off   = redo_chunk ? cur_off : (reach_end ? OFF_END : sum_off);
  assign rsp_stat  = reach_end ? RSP_DONE : RSP_MORE;

  mbox_resp_gen #(.VENDOR_ID(VENDOR_ID)) u_rsp (
    .clk    (clk),
    .rst    (rst),
    .clr    (abort_fire || (go_fire && !req_ok)),
    .load   (go_fire && req_ok),
    .ld_off (rsp_off),
    .ld_stat(rsp_stat),
    .ack    (ack_fire),
    .valid  (resp_valid),
    .dword  (resp_dword)
  );

  always_ff @(posedge clk) begin
    if (rst || abort_fire) begin
      st_ready     <= 1'b0;
      st_err       <= 1'b0;
      cur_off      <= '0;
      chunk_dwords <= '0;
    end else if (go_fire) begin
      st_ready <= 1'b1;
      st_err   <= !req_ok;
      if (req_ok) begin
        chunk_dwords <= CNT_W'(pay_dw);
        if (!redo_chunk) cur_off <= reach_end ? img_bytes : sum_off;
      end
    end else if (wd_fire) begin
      st_ready <= 1'b0;
      st_err   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (reg_sel)
        RG_STAT:  bus_rdata <= {st_ready, 28'h0, st_err, 2'b00};
        RG_RDATA: bus_rdata <= resp_valid ? resp_dword : 32'h0;
        default:  bus_rdata <= 32'h0;
      endcase
    end
  end

  assert_abort_idle_R1: assert property (@(posedge clk) disable iff (rst)
    abort_fire |=> (!st_ready && !st_err && !resp_valid && cur_off == '0));
  assert_err_has_ready_R2: assert property (@(posedge clk) disable iff (rst)
    st_err |-> st_ready);
  assert_bad_noreply_R7: assert property (@(posedge clk) disable iff (rst)
    (go_fire && !req_ok) |=> (st_err && !resp_valid && $stable(cur_off)));
  assert_redo_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (go_fire && req_ok && redo_chunk) |=> $stable(cur_off));
  assert_abort_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && reg_sel == RG_CTRL && bus_wdata[0] && bus_wdata[31]) |=> !st_ready);
endmodule

// File: tb/sim_mbox_stager.sv
module sim_mbox_stager;
  localparam int          CDW = 8;
  localparam logic [15:0] VID = 16'h1A2B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] img_bytes = 32'd64;
  logic        redo_chunk = 1'b0;
  logic [2:0]  chunk_raddr = '0;
  logic [31:0] chunk_rdata;
  logic [3:0]  chunk_dwords;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mbox_stager #(.CHUNK_DW(CDW), .VENDOR_ID(VID)) u0 (
    .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
    .img_bytes, .redo_chunk, .chunk_raddr, .chunk_rdata, .chunk_dwords
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_req(input logic [15:0] vid, input logic [7:0] ot,
                          input logic [31:0] cmd, input int ndata,
                          input logic [31:0] hcount, input logic [31:0] base);
    wr(4'h8, {8'h00, ot, vid});
    wr(4'h8, hcount);
    wr(4'h8, cmd);
    wr(4'h8, 32'h0);
    for (int i = 0; i < ndata; i++) wr(4'h8, base + 32'(i));
  endtask

  task automatic good_req(input int ndata, input logic [31:0] base);
    send_req(VID, 8'h0B, 32'h3, ndata, 32'(ndata + 4), base);
    wr(4'h0, 32'h8000_0000);
  endtask

  task automatic expect_reply(input string req, input logic [31:0] off, input logic [31:0] st);
    logic [31:0] d;
    rd(4'hC, d); check({req, " hdr lo"}, d, {8'h00, 8'h0B, VID}); wr(4'hC, 32'h0);
    rd(4'hC, d); check({req, " hdr hi"}, d, 32'd4);               wr(4'hC, 32'h0);
    rd(4'hC, d); check({req, " offset"}, d, off);                 wr(4'hC, 32'h0);
    rd(4'hC, d); check({req, " status"}, d, st);                  wr(4'hC, 32'h0);
    rd(4'hC, d); check("R4 drained", d, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h4, d); check("R1 status after reset", d, 32'h0);
    rd(4'hC, d); check("R1 rdata after reset", d, 32'h0);
    rd(4'h0, d); check("R2 control reads 0", d, 32'h0);
    rd(4'h8, d); check("R2 wdata reads 0", d, 32'h0);
  endtask

  task automatic t_walk;
    logic [31:0] d;
    wr(4'h0, 32'h1);
    good_req(8, 32'hC0DE_0000);
    rd(4'h4, d); check("R3 ready after good go", d, 32'h8000_0000);
    check("R9 chunk count", 32'(chunk_dwords), 32'd8);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); chunk_raddr = 3'(k);
      @(negedge clk); check("R9 chunk data", chunk_rdata, 32'hC0DE_0000 + 32'(k));
    end
    expect_reply("R4 R5 first", 32'd32, 32'h2);
    wr(4'hC, 32'h0);
    rd(4'hC, d); check("R4 ack without reply ignored", d, 32'h0);
    wr(4'h8, {8'h00, 8'h0B, VID});
    rd(4'h4, d); check("R8 status cleared by new write", d, 32'h0);
    wr(4'h0, 32'h1);
    good_req(8, 32'hA000_0000);
    expect_reply("R5 step", 32'd32, 32'h2);
    @(negedge clk); redo_chunk = 1'b1;
    good_req(8, 32'hB000_0000);
    @(negedge clk); redo_chunk = 1'b0;
    expect_reply("R6 redo", 32'd32, 32'h2);
    good_req(8, 32'hB000_0000);
    expect_reply("R5 end", 32'hFFFF_FFFF, 32'h1);
  endtask

  task automatic t_errors;
    logic [31:0] d;
    wr(4'h0, 32'h1);
    send_req(16'h0001, 8'h0B, 32'h3, 2, 32'd6, 0); wr(4'h0, 32'h8000_0000);
    rd(4'h4, d); check("R7 bad vendor", d, 32'h8000_0004);
    rd(4'hC, d); check("R7 no reply", d, 32'h0);
    send_req(VID, 8'h0C, 32'h3, 2, 32'd6, 0); wr(4'h0, 32'h8000_0000);
    rd(4'h4, d); check("R7 bad type", d, 32'h8000_0004);
    send_req(VID, 8'h0B, 32'h4, 2, 32'd6, 0); wr(4'h0, 32'h8000_0000);
    rd(4'h4, d); check("R7 bad command", d, 32'h8000_0004);
    send_req(VID, 8'h0B, 32'h3, 2, 32'd7, 0); wr(4'h0, 32'h8000_0000);
    rd(4'h4, d); check("R7 count mismatch", d, 32'h8000_0004);
    send_req(VID, 8'h0B, 32'h3, 9, 32'd13, 0); wr(4'h0, 32'h8000_0000);
    rd(4'h4, d); check("R7 too many dwords", d, 32'h8000_0004);
    wr(4'h0, 32'h8000_0000);
    rd(4'h4, d); check("R7 empty request", d, 32'h8000_0004);
    good_req(4, 32'h5);
    expect_reply("R7 offset not moved", 32'd16, 32'h2);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    send_req(VID, 8'h0B, 32'h3, 4, 32'd8, 0);
    wr(4'h0, 32'h8000_0001);
    rd(4'h4, d); check("R10 abort wins over go", d, 32'h0);
    rd(4'hC, d); check("R10 no reply", d, 32'h0);
    good_req(4, 32'h9);
    rd(4'hC, d); check("R1 reply live", d, {8'h00, 8'h0B, VID});
    wr(4'hC, 32'h0);
    wr(4'h0, 32'h1);
    rd(4'hC, d); check("R1 abort mid reply", d, 32'h0);
    rd(4'h4, d); check("R1 status after abort", d, 32'h0);
    good_req(4, 32'h9);
    expect_reply("R1 offset restarted", 32'd16, 32'h2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_walk();
    t_errors();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule